// File: doc/BRIEF.md
# CRT Controller Host Register File

This block is the register file a host processor uses to program a character-based CRT controller. The host first writes a register index to a select port. Later data writes and data reads then go to that index. Each write is trimmed to the bits that register really holds. The stored values are decoded continuously into timing fields for the raster counters: horizontal total, displayed and sync position, sync widths, vertical total, adjust, displayed and sync position, interlace mode, scanlines per row and cursor shape. The block also assembles the display start address and the cursor address from their high and low bytes.

A light-pen strobe takes a snapshot of the refresh address the timing generator is currently presenting. It also raises a flag in the status byte. The host reads the snapshot back through two of the registers, and that read lowers the flag. The status byte also mirrors the vertical sync signal from the timing generator.

Top module: `crtc_regfile`

## Requirements
- R1: A pulse on `sel_we` stores `sel_idx` (5 bits) on the clock edge. Data writes and reads that follow use that stored index. After reset the stored index is 0.
- R2: `rd_data` is 0x00 whenever the stored index is below 12 or above 17, whatever has been written.
- R3: A write stores only the bits of its register's mask, and indices 12 to 15 read back the masked value. The masks are: indices 0 to 3 use 0xFF; index 4 uses 0x7F; index 5 uses 0x1F; indices 6 and 7 use 0x7F; index 8 uses 0x03; index 9 uses 0x1F; index 10 uses 0x7F; index 11 uses 0x1F; indices 12 and 14 use 0x3F; indices 13 and 15 use 0xFF.
- R4: Index 3 supplies the horizontal sync width from bits 3:0 (`hs_width`) and the vertical sync length from bits 7:4 (`vs_length`).
- R5: Bits 1:0 of index 8 set `ilace_mode`. The value 01 gives 1 (sync only), 11 gives 2 (sync and video), and 00 or 10 give 0 (off).
- R6: `start_addr` is {index 12 bits 5:0, index 13}. `cursor_addr` is {index 14 bits 5:0, index 15}.
- R7: A cycle with `lpen_strobe` high captures `refresh_addr`. Index 16 then reads bits 13:8 of the captured address in its low six bits, and index 17 reads bits 7:0. From the next cycle, bit 6 of `status` is 1.
- R8: A cycle with `rd_en` high while the stored index is 16 or 17 clears status bit 6 from the next cycle. If `lpen_strobe` is also high in that cycle, the bit stays 1.
- R9: Bit 5 of `status` follows `vsync_in` in the same cycle. Status bits other than 5 and 6 are 0.
- R10: Writes to indices 16 to 31 change nothing: readback of index 16 and 17, the status byte and every decoded output stay the same.
- R11: Synchronous reset clears every register, the captured address and the status flag, so every decoded output and every readable index read 0.
- R12: Decoded fields come straight from their indices: 0 `h_total`, 1 `h_disp`, 2 `h_sync_pos`, 4 `v_total`, 5 `v_adjust`, 6 `v_disp`, 7 `v_sync_pos`, 9 `max_scan`, 10 bits 4:0 `cur_first` and bits 6:5 `cur_blink`, 11 `cur_last`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_we | input | 1 | Strobe that loads the register index |
| sel_idx | input | 5 | Register index to load |
| wr_en | input | 1 | Data write strobe to the selected register |
| wr_data | input | 8 | Data written |
| rd_en | input | 1 | Data read strobe (clears the light-pen flag for index 16 or 17) |
| rd_data | output | 8 | Readback of the selected register |
| status | output | 8 | Bit 6 light-pen flag, bit 5 vertical sync |
| vsync_in | input | 1 | Vertical sync from the timing generator |
| lpen_strobe | input | 1 | Light-pen capture strobe |
| refresh_addr | input | 14 | Current refresh address |
| h_total | output | 8 | Horizontal total |
| h_disp | output | 8 | Horizontal displayed characters |
| h_sync_pos | output | 8 | Horizontal sync position |
| hs_width | output | 4 | Horizontal sync width |
| vs_length | output | 4 | Vertical sync length |
| v_total | output | 7 | Vertical total rows |
| v_adjust | output | 5 | Vertical adjust lines |
| v_disp | output | 7 | Vertical displayed rows |
| v_sync_pos | output | 7 | Vertical sync row |
| ilace_mode | output | 2 | 0 off, 1 sync only, 2 sync and video |
| max_scan | output | 5 | Last scanline of a row |
| cur_first | output | 5 | Cursor first scanline |
| cur_last | output | 5 | Cursor last scanline |
| cur_blink | output | 2 | Cursor blink control |
| start_addr | output | 14 | Display start address |
| cursor_addr | output | 14 | Cursor address |

## Verification
The hardest case to reach is a light-pen strobe that lands in the very cycle the host reads the captured address. The bench sets up that collision on purpose: it raises the flag, selects index 16, and then drives `rd_en` and `lpen_strobe` together in one cycle. It then checks that the flag stays set and that a later read on its own clears it. The bench also sweeps every one of the 32 indices with several data patterns while keeping a shadow model. After each write it compares the readback and every decoded field against that model. This covers the zero readback, the masks and the ignored upper indices.

// File: rtl/crtc_regs_pkg.sv
package crtc_regs_pkg;

    localparam int DW      = 8;
    localparam int RD_LO   = 12;
    localparam int LP_HI   = 16;
    localparam int LP_LO   = 17;
    localparam int STAT_LP = 6;
    localparam int STAT_VS = 5;

    typedef enum logic [1:0] {
        ILACE_OFF   = 2'd0,
        ILACE_SYNC  = 2'd1,
        ILACE_VIDEO = 2'd2
    } ilace_e;

    typedef struct packed {
        logic [7:0] h_total;
        logic [7:0] h_disp;
        logic [7:0] h_sync_pos;
        logic [3:0] hs_width;
        logic [3:0] vs_length;
        logic [6:0] v_total;
        logic [4:0] v_adjust;
        logic [6:0] v_disp;
        logic [6:0] v_sync_pos;
        ilace_e     ilace;
        logic [4:0] max_scan;
        logic [4:0] cur_first;
        logic [1:0] cur_blink;
        logic [4:0] cur_last;
    } timing_t;

    // Bits each writable register keeps; aw is the refresh address width.
    function automatic logic [DW-1:0] wr_mask(input int idx, input int aw);
        logic [DW-1:0] hi;
        hi = DW'((1 << (aw - DW)) - 1);
        case (idx)
            0, 1, 2, 3: return 8'hFF;
            4, 6, 7:    return 8'h7F;
            5, 9, 11:   return 8'h1F;
            8:          return 8'h03;
            10:         return 8'h7F;
            12, 14:     return hi;
            default:    return 8'hFF;
        endcase
    endfunction

    function automatic ilace_e ilace_decode(input logic [1:0] b);
        case (b)
            2'b01:   return ILACE_SYNC;
            2'b11:   return ILACE_VIDEO;
            default: return ILACE_OFF;
        endcase
    endfunction

endpackage

// File: rtl/crtc_reg_store.sv
module crtc_reg_store
    import crtc_regs_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int NUM_WR = 16,
    parameter int ADDR_W = 14
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        sel_we,
    input  logic [IDX_W-1:0]            sel_idx,
    input  logic                        wr_en,
    input  logic [DW-1:0]               wr_data,
    output logic [IDX_W-1:0]            sel_q,
    output logic [NUM_WR-1:0][DW-1:0]   regs
);

    always_ff @(posedge clk) begin
        if (rst)         sel_q <= '0;
        else if (sel_we) sel_q <= sel_idx;
    end

    AST_SEL_LATCH: assert property (@(posedge clk) disable iff (rst)
        sel_we |=> sel_q == $past(sel_idx)); // R1

    genvar g;
    generate
        for (g = 0; g < NUM_WR; g++) begin : g_reg
            localparam logic [DW-1:0] MASK = wr_mask(g, ADDR_W);
            logic [DW-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)                                  q <= '0;
                else if (wr_en && sel_q == IDX_W'(g))     q <= wr_data & MASK;
            end
            assign regs[g] = q;

            AST_WR_MASKED: assert property (@(posedge clk) disable iff (rst)
                (wr_en && sel_q == IDX_W'(g)) |=> regs[g] == ($past(wr_data) & MASK)); // R3
        end
    endgenerate

    AST_HIGH_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel_q >= IDX_W'(NUM_WR)) |=> $stable(regs)); // R10

endmodule

// File: rtl/crtc_lpen.sv
module crtc_lpen #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic              clr_req,
    output logic [ADDR_W-1:0] lp_addr,
    output logic              lp_flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lp_addr <= '0;
            lp_flag <= 1'b0;
        end else begin
            if (strobe) lp_addr <= ref_addr;
            // A capture in the same cycle as a clearing read wins.
            if (strobe)       lp_flag <= 1'b1;
            else if (clr_req) lp_flag <= 1'b0;
        end
    end

    AST_LP_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        strobe |=> lp_flag); // R7

    AST_LP_FLAG_CLR: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !strobe) |=> !lp_flag); // R8

    AST_LP_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(lp_addr)); // R10

endmodule

// File: rtl/crtc_field_decode.sv
module crtc_field_decode
    import crtc_regs_pkg::*;
#(
    parameter int NUM_WR = 16,
    parameter int ADDR_W = 14
) (
    input  logic [NUM_WR-1:0][DW-1:0] regs,
    output timing_t                   tm,
    output logic [ADDR_W-1:0]         start_addr,
    output logic [ADDR_W-1:0]         cursor_addr
);
    localparam int HI_W = ADDR_W - DW;

    always_comb begin
        tm.h_total    = regs[0];
        tm.h_disp     = regs[1];
        tm.h_sync_pos = regs[2];
        tm.hs_width   = regs[3][3:0];
        tm.vs_length  = regs[3][7:4];
        tm.v_total    = regs[4][6:0];
        tm.v_adjust   = regs[5][4:0];
        tm.v_disp     = regs[6][6:0];
        tm.v_sync_pos = regs[7][6:0];
        tm.ilace      = ilace_decode(regs[8][1:0]);
        tm.max_scan   = regs[9][4:0];
        tm.cur_first  = regs[10][4:0];
        tm.cur_blink  = regs[10][6:5];
        tm.cur_last   = regs[11][4:0];
    end

    assign start_addr  = {regs[12][HI_W-1:0], regs[13]};
    assign cursor_addr = {regs[14][HI_W-1:0], regs[15]};

endmodule

// File: rtl/crtc_regfile.sv
module crtc_regfile
    import crtc_regs_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int NUM_WR = 16,
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_we,
    input  logic [IDX_W-1:0]  sel_idx,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    output logic [7:0]        rd_data,
    output logic [7:0]        status,
    input  logic              vsync_in,
    input  logic              lpen_strobe,
    input  logic [ADDR_W-1:0] refresh_addr,
    output logic [7:0]        h_total,
    output logic [7:0]        h_disp,
    output logic [7:0]        h_sync_pos,
    output logic [3:0]        hs_width,
    output logic [3:0]        vs_length,
    output logic [6:0]        v_total,
    output logic [4:0]        v_adjust,
    output logic [6:0]        v_disp,
    output logic [6:0]        v_sync_pos,
    output logic [1:0]        ilace_mode,
    output logic [4:0]        max_scan,
    output logic [4:0]        cur_first,
    output logic [4:0]        cur_last,
    output logic [1:0]        cur_blink,
    output logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] cursor_addr
);
    localparam int REG_AW = $clog2(NUM_WR);
    localparam int PAD_W  = 2 * DW - ADDR_W;

    logic [IDX_W-1:0]          sel_q;
    logic [NUM_WR-1:0][DW-1:0] regs;
    logic [ADDR_W-1:0]         lp_addr;
    logic                      lp_flag;
    logic                      lp_sel;
    timing_t                   tm;

    crtc_reg_store #(.IDX_W(IDX_W), .NUM_WR(NUM_WR), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst(rst), .sel_we(sel_we), .sel_idx(sel_idx),
        .wr_en(wr_en), .wr_data(wr_data), .sel_q(sel_q), .regs(regs)
    );

    assign lp_sel = (sel_q == IDX_W'(LP_HI)) || (sel_q == IDX_W'(LP_LO));

    crtc_lpen #(.ADDR_W(ADDR_W)) u_lpen (
        .clk(clk), .rst(rst), .strobe(lpen_strobe), .ref_addr(refresh_addr),
        .clr_req(rd_en && lp_sel), .lp_addr(lp_addr), .lp_flag(lp_flag)
    );

    crtc_field_decode #(.NUM_WR(NUM_WR), .ADDR_W(ADDR_W)) u_dec (
        .regs(regs), .tm(tm), .start_addr(start_addr), .cursor_addr(cursor_addr)
    );

    always_comb begin
        rd_data = '0;
        if (sel_q >= IDX_W'(RD_LO) && sel_q < IDX_W'(NUM_WR))
            rd_data = regs[sel_q[REG_AW-1:0]];
        else if (sel_q == IDX_W'(LP_HI))
            rd_data = {{PAD_W{1'b0}}, lp_addr[ADDR_W-1:DW]};
        else if (sel_q == IDX_W'(LP_LO))
            rd_data = lp_addr[DW-1:0];
    end

    always_comb begin
        status          = '0;
        status[STAT_LP] = lp_flag;
        status[STAT_VS] = vsync_in;
    end

    assign h_total    = tm.h_total;
    assign h_disp     = tm.h_disp;
    assign h_sync_pos = tm.h_sync_pos;
    assign hs_width   = tm.hs_width;
    assign vs_length  = tm.vs_length;
    assign v_total    = tm.v_total;
    assign v_adjust   = tm.v_adjust;
    assign v_disp     = tm.v_disp;
    assign v_sync_pos = tm.v_sync_pos;
    assign ilace_mode = tm.ilace;
    assign max_scan   = tm.max_scan;
    assign cur_first  = tm.cur_first;
    assign cur_last   = tm.cur_last;
    assign cur_blink  = tm.cur_blink;

endmodule

// File: tb/tb_crtc_regfile.sv
`timescale 1ns/1ps
module tb_crtc_regfile;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_we = 1'b0;
    logic [4:0]  sel_idx = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data, status;
    logic        vsync_in = 1'b0;
    logic        lpen_strobe = 1'b0;
    logic [13:0] refresh_addr = '0;
    logic [7:0]  h_total, h_disp, h_sync_pos;
    logic [3:0]  hs_width, vs_length;
    logic [6:0]  v_total, v_disp, v_sync_pos;
    logic [4:0]  v_adjust, max_scan, cur_first, cur_last;
    logic [1:0]  ilace_mode, cur_blink;
    logic [13:0] start_addr, cursor_addr;

    int errors = 0;
    int checks = 0;
    logic [7:0]  shadow [16];
    logic [13:0] lp_model = '0;
    logic        flag_model = 1'b0;

    always #5 clk = ~clk;

    crtc_regfile dut (
        .clk(clk), .rst(rst), .sel_we(sel_we), .sel_idx(sel_idx),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .status(status), .vsync_in(vsync_in), .lpen_strobe(lpen_strobe),
        .refresh_addr(refresh_addr), .h_total(h_total), .h_disp(h_disp),
        .h_sync_pos(h_sync_pos), .hs_width(hs_width), .vs_length(vs_length),
        .v_total(v_total), .v_adjust(v_adjust), .v_disp(v_disp),
        .v_sync_pos(v_sync_pos), .ilace_mode(ilace_mode), .max_scan(max_scan),
        .cur_first(cur_first), .cur_last(cur_last), .cur_blink(cur_blink),
        .start_addr(start_addr), .cursor_addr(cursor_addr)
    );

    function automatic logic [7:0] bmask(input int i);
        if (i <= 3) return 8'hFF;
        if (i == 4 || i == 6 || i == 7 || i == 10) return 8'h7F;
        if (i == 5 || i == 9 || i == 11) return 8'h1F;
        if (i == 8) return 8'h03;
        if (i == 12 || i == 14) return 8'h3F;
        return 8'hFF;
    endfunction

    function automatic logic [7:0] exp_read(input int i);
        if (i >= 12 && i <= 15) return shadow[i];
        if (i == 16) return {2'b00, lp_model[13:8]};
        if (i == 17) return lp_model[7:0];
        return 8'h00;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic check_decode();
        logic [1:0] b;
        int m;
        b = shadow[8][1:0];
        m = (b == 2'b01) ? 1 : (b == 2'b11) ? 2 : 0;
        chk("R12 h_total",    32'(h_total),    32'(shadow[0]));
        chk("R12 h_disp",     32'(h_disp),     32'(shadow[1]));
        chk("R12 h_sync_pos", 32'(h_sync_pos), 32'(shadow[2]));
        chk("R4 hs_width",    32'(hs_width),   32'(shadow[3] % 16));
        chk("R4 vs_length",   32'(vs_length),  32'(shadow[3] / 16));
        chk("R12 v_total",    32'(v_total),    32'(shadow[4]));
        chk("R12 v_adjust",   32'(v_adjust),   32'(shadow[5]));
        chk("R12 v_disp",     32'(v_disp),     32'(shadow[6]));
        chk("R12 v_sync_pos", 32'(v_sync_pos), 32'(shadow[7]));
        chk("R5 ilace_mode",  32'(ilace_mode), 32'(m));
        chk("R12 max_scan",   32'(max_scan),   32'(shadow[9]));
        chk("R12 cur_first",  32'(cur_first),  32'(shadow[10] % 32));
        chk("R12 cur_blink",  32'(cur_blink),  32'(shadow[10] / 32));
        chk("R12 cur_last",   32'(cur_last),   32'(shadow[11]));
        chk("R6 start_addr",  32'(start_addr), 32'(shadow[12]) * 256 + 32'(shadow[13]));
        chk("R6 cursor_addr", 32'(cursor_addr), 32'(shadow[14]) * 256 + 32'(shadow[15]));
    endtask

    task automatic do_sel(input int i);
        @(negedge clk); sel_we = 1'b1; sel_idx = 5'(i);
        @(negedge clk); sel_we = 1'b0;
    endtask

    task automatic do_wr(input int i, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
        if (i < 16) shadow[i] = d & bmask(i);
    endtask

    task automatic do_cycle(input logic strobe, input logic rd, input logic [13:0] ra);
        @(negedge clk); lpen_strobe = strobe; rd_en = rd; refresh_addr = ra;
        @(negedge clk); lpen_strobe = 1'b0; rd_en = 1'b0;
        if (strobe) begin lp_model = ra; flag_model = 1'b1; end
        else if (rd) flag_model = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        chk("R11 rd_data idx0", 32'(rd_data), 32'h0);
        chk("R11 status",       32'(status),  32'h0);
        check_decode();
        for (int i = 12; i <= 17; i++) begin
            do_sel(i);
            chk("R11 readback", 32'(rd_data), 32'h0);
        end

        // Sweep every index with several patterns
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 32; i++) begin
                logic [7:0] d;
                d = (p == 0) ? 8'hFF : (p == 1) ? 8'hA5 : (p == 2) ? 8'h5A : 8'((i * 37 + 11) ^ 8'hC3);
                do_sel(i);
                chk("R1 select", 32'(rd_data), 32'(exp_read(i)));
                do_wr(i, d);
                if (i < 12 || i > 17) chk("R2 zero readback", 32'(rd_data), 32'h0);
                else if (i <= 15)     chk("R3 masked readback", 32'(rd_data), 32'(exp_read(i)));
                else                  chk("R10 lp readback", 32'(rd_data), 32'(exp_read(i)));
                check_decode();
            end
        end

        // Interlace decode for every bit pattern
        do_sel(8);
        for (int v = 0; v < 16; v++) begin
            do_wr(8, 8'(v * 17));
            check_decode();
        end

        // Light pen capture and clear
        do_cycle(1'b1, 1'b0, 14'h2ABC);
        chk("R7 status flag", 32'(status), 32'h40);
        do_sel(17);
        chk("R7 low byte", 32'(rd_data), 32'hBC);
        do_sel(16);
        chk("R7 high byte", 32'(rd_data), 32'h2A);
        do_cycle(1'b0, 1'b1, 14'h0);
        chk("R8 flag cleared", 32'(status), 32'h00);
        chk("R8 data kept", 32'(rd_data), 32'h2A);

        // Strobe coincident with clearing read
        do_cycle(1'b1, 1'b0, 14'h1357);
        do_cycle(1'b1, 1'b1, 14'h3FFF);
        chk("R8 collision flag", 32'(status), 32'h40);
        chk("R7 collision data", 32'(rd_data), 32'h3F);
        do_sel(17);
        do_cycle(1'b0, 1'b1, 14'h0);
        chk("R8 later clear", 32'(status), 32'h00);
        chk("R7 low after clear", 32'(rd_data), 32'hFF);

        // Rd with index not 16/17 keeps flag
        do_cycle(1'b1, 1'b0, 14'h0042);
        do_sel(13);
        do_cycle(1'b0, 1'b1, 14'h0);
        chk("R8 other idx keeps flag", 32'(status), 32'h40);

        // Writes to upper indices ignored
        do_sel(16);
        do_wr(16, 8'hFF);
        chk("R10 wr16 readback", 32'(rd_data), 32'h00);
        chk("R10 wr16 status", 32'(status), 32'h40);
        do_sel(17);
        do_wr(17, 8'h00);
        chk("R10 wr17 readback", 32'(rd_data), 32'h42);
        check_decode();

        // Vertical sync mirror
        @(negedge clk); vsync_in = 1'b1; #1;
        chk("R9 vsync with flag", 32'(status), 32'h60);
        do_sel(16);
        do_cycle(1'b0, 1'b1, 14'h0);
        chk("R9 vsync only", 32'(status), 32'h20);
        @(negedge clk); vsync_in = 1'b0; #1;
        chk("R9 vsync low", 32'(status), 32'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule